// File: doc/BRIEF.md
# Caller ID Frame Parser

This block sits behind an asynchronous 1200 bps byte receiver and turns the stream of received bytes into a parsed calling-number message. Parsing begins with the first byte after the alternating preamble and the mark period. That byte is the message type. The next byte is the payload length. After the payload comes one checksum byte. Bit 7 of the type byte selects between two payload layouts. In the plain layout the payload is a run of date, time and number bytes. In the parameter layout the payload is a chain of parameters, and each parameter is a tag byte, a count byte and that many data bytes.

Payload bytes are written in arrival order into a small buffer, which a host reads through an address/data port. When the message ends, a one-cycle done pulse is raised together with a pass flag for the checksum. A sticky length-error flag and a sticky buffer-overflow flag are also reported. A carrier-valid input gates the byte stream. If the carrier drops during a message, the partial message is abandoned without a done pulse.

Top module: `cid_frame_parser`

## Requirements
- R1: The first byte accepted while idle is captured on `msg_type`. Its bit 7 is copied to `msg_multi`: 1 selects the parameter layout and 0 selects the plain layout. `msg_type` changes only when a byte is accepted.
- R2: The second byte is captured on `msg_len` as the payload byte count. A count of 0 makes the third byte the checksum.
- R3: In the plain layout the next `msg_len` bytes are payload. Payload byte k is readable on `rd_data` when `rd_addr` = k (combinational read).
- R4: The byte after the payload is the checksum. `done` is high for exactly the one cycle after the edge that accepts it. `pass` is 1 when the 8-bit wrap-around sum of every byte from the type byte through the checksum byte is zero, and 0 otherwise.
- R5: In the parameter layout the payload is walked as tag, count and then count data bytes, repeated. Tag and count bytes are stored in the buffer like any other payload byte. A count of 0 is allowed.
- R6: A parameter count larger than the payload bytes still remaining after it, or a tag byte that is the last payload byte, ends the message at that byte. That ending raises `done` with `len_err`=1 and `pass`=0, and the next byte is taken as a new type byte.
- R7: A payload byte at index BUF_DEPTH (64) or above is not stored and sets `buf_ovf`. The message still completes normally.
- R8: While `carrier_ok` is 0, bytes are ignored and any partial message is abandoned without a `done` pulse. The first byte accepted afterwards is a type byte.
- R9: After reset `done`, `pass`, `len_err`, `buf_ovf`, `msg_multi`, `msg_type` and `msg_len` are all 0.
- R10: A byte is accepted only on a clock edge where `byte_valid` and `carrier_ok` are both 1. Idle cycles between bytes have no effect.
- R11: `pass`, `len_err` and `buf_ovf` keep their values from the end of a message until the next type byte is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_ok | input | 1 | Carrier present; low aborts the parse |
| byte_valid | input | 1 | A received byte is on byte_data this cycle |
| byte_data | input | BYTE_W | Received byte |
| rd_addr | input | $clog2(BUF_DEPTH) | Payload buffer read address |
| rd_data | output | BYTE_W | Payload buffer read data |
| done | output | 1 | One-cycle end-of-message pulse |
| pass | output | 1 | Checksum verdict of the last message |
| len_err | output | 1 | Last message ended on a parameter overrun |
| buf_ovf | output | 1 | Last message had more payload than the buffer holds |
| msg_type | output | BYTE_W | Captured type byte |
| msg_len | output | BYTE_W | Captured payload length |
| msg_multi | output | 1 | Parameter layout selected |

## Verification
A wrong parse state shows up as a misplaced `done`. A lost or extra count makes the pulse land one or more bytes early or late, and it can flip `len_err` on the very byte where the parameter walk goes astray. A bad running sum is visible only at `pass`, one cycle after the checksum byte. A wrong write pointer is visible only by reading the buffer back. The reference model is compared on every cycle, so a divergence is reported in the cycle it first reaches a port, and buffer contents are read back after each message.

// File: rtl/cid_pkg.sv
package cid_pkg;
   typedef enum logic [2:0] {
      ST_TYPE,
      ST_LEN,
      ST_DATA,
      ST_PTYP,
      ST_PLEN,
      ST_PDAT,
      ST_CHK
   } cid_state_t;
endpackage

// File: rtl/cid_buf.sv
module cid_buf #(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 64,
   parameter int AW     = 6,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) rd_data <= mem[rd_addr];
      end else begin : g_rd_comb
         assign rd_data = mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/cid_fsm.sv
module cid_fsm
   import cid_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int DEPTH     = 64,
   parameter int AW        = 6,
   parameter int MULTI_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carrier_ok,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              done,
   output logic              pass,
   output logic              len_err,
   output logic              buf_ovf,
   output logic [BYTE_W-1:0] msg_type,
   output logic [BYTE_W-1:0] msg_len,
   output logic              msg_multi
);
   localparam int CW = BYTE_W + 1;
   localparam logic [CW-1:0]     DEPTH_V = CW'(DEPTH);
   localparam logic [BYTE_W-1:0] ONE     = BYTE_W'(1);
   localparam logic [BYTE_W-1:0] ZERO    = '0;

   cid_state_t        state;
   logic [BYTE_W-1:0] rem, prem, sum;
   logic [CW-1:0]     wcnt;
   logic              acc, store;
   logic [BYTE_W-1:0] rem_m1, sum_nx;

   assign acc    = byte_valid & carrier_ok;
   assign rem_m1 = rem - ONE;
   assign sum_nx = sum + byte_data;

   always_comb begin
      store = 1'b0;
      if (acc) begin
         case (state)
            ST_DATA, ST_PTYP, ST_PLEN, ST_PDAT: store = 1'b1;
            default: store = 1'b0;
         endcase
      end
   end

   assign wr_en   = store && (wcnt < DEPTH_V);
   assign wr_addr = wcnt[AW-1:0];
   assign wr_data = byte_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_TYPE;
         rem       <= '0;
         prem      <= '0;
         sum       <= '0;
         wcnt      <= '0;
         done      <= 1'b0;
         pass      <= 1'b0;
         len_err   <= 1'b0;
         buf_ovf   <= 1'b0;
         msg_type  <= '0;
         msg_len   <= '0;
         msg_multi <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!carrier_ok) begin
            state <= ST_TYPE;
         end else if (byte_valid) begin
            sum <= sum_nx;
            if (store) begin
               wcnt <= wcnt + CW'(1);
               if (wcnt >= DEPTH_V) buf_ovf <= 1'b1;
            end
            case (state)
               ST_TYPE: begin
                  msg_type  <= byte_data;
                  msg_multi <= byte_data[MULTI_BIT];
                  sum       <= byte_data;
                  wcnt      <= '0;
                  pass      <= 1'b0;
                  len_err   <= 1'b0;
                  buf_ovf   <= 1'b0;
                  state     <= ST_LEN;
               end
               ST_LEN: begin
                  msg_len <= byte_data;
                  rem     <= byte_data;
                  if (byte_data == ZERO) state <= ST_CHK;
                  else if (msg_multi)    state <= ST_PTYP;
                  else                   state <= ST_DATA;
               end
               ST_DATA: begin
                  rem <= rem_m1;
                  if (rem == ONE) state <= ST_CHK;
               end
               ST_PTYP: begin
                  rem <= rem_m1;
                  if (rem == ONE) begin
                     done    <= 1'b1;
                     len_err <= 1'b1;
                     pass    <= 1'b0;
                     state   <= ST_TYPE;
                  end else begin
                     state <= ST_PLEN;
                  end
               end
               ST_PLEN: begin
                  rem  <= rem_m1;
                  prem <= byte_data;
                  if (byte_data > rem_m1) begin
                     done    <= 1'b1;
                     len_err <= 1'b1;
                     pass    <= 1'b0;
                     state   <= ST_TYPE;
                  end else if (byte_data == ZERO) begin
                     state <= (rem_m1 == ZERO) ? ST_CHK : ST_PTYP;
                  end else begin
                     state <= ST_PDAT;
                  end
               end
               ST_PDAT: begin
                  rem  <= rem_m1;
                  prem <= prem - ONE;
                  if (prem == ONE) state <= (rem == ONE) ? ST_CHK : ST_PTYP;
               end
               ST_CHK: begin
                  done  <= 1'b1;
                  pass  <= (sum_nx == ZERO);
                  state <= ST_TYPE;
               end
               default: state <= ST_TYPE;
            endcase
         end
      end
   end
endmodule

// File: rtl/cid_frame_parser.sv
module cid_frame_parser #(
   parameter int BYTE_W    = 8,
   parameter int BUF_DEPTH = 64,
   parameter int MULTI_BIT = 7,
   parameter bit RD_REG    = 1'b0,
   localparam int AW       = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carrier_ok,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              done,
   output logic              pass,
   output logic              len_err,
   output logic              buf_ovf,
   output logic [BYTE_W-1:0] msg_type,
   output logic [BYTE_W-1:0] msg_len,
   output logic              msg_multi
);
   generate
      if (BUF_DEPTH < 2 || BUF_DEPTH > (1 << BYTE_W)) begin : g_bad_depth
         $error("BUF_DEPTH must lie between 2 and 2**BYTE_W");
      end
      if (MULTI_BIT >= BYTE_W) begin : g_bad_bit
         $error("MULTI_BIT must address a bit of the type byte");
      end
   endgenerate

   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [BYTE_W-1:0] wr_data;

   cid_fsm #(
      .BYTE_W(BYTE_W), .DEPTH(BUF_DEPTH), .AW(AW), .MULTI_BIT(MULTI_BIT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .pass(pass), .len_err(len_err), .buf_ovf(buf_ovf),
      .msg_type(msg_type), .msg_len(msg_len), .msg_multi(msg_multi)
   );

   cid_buf #(
      .BYTE_W(BYTE_W), .DEPTH(BUF_DEPTH), .AW(AW), .RD_REG(RD_REG)
   ) u_buf (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: rtl/cid_frame_parser_chk.sv
module cid_frame_parser_chk #(
   parameter int BYTE_W    = 8,
   parameter int BUF_DEPTH = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              carrier_ok,
   input logic              byte_valid,
   input logic              done,
   input logic              pass,
   input logic              len_err,
   input logic              buf_ovf,
   input logic [BYTE_W-1:0] msg_type,
   input logic [BYTE_W-1:0] msg_len,
   input logic              msg_multi
);
   // R4: the end-of-message pulse lasts one cycle
   a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: no done after an edge without carrier
   a_r8_no_done_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_ok |=> !done);

   // R10: no done after an edge without a byte
   a_r10_no_byte_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> !done);

   // R10 / R1: captured type holds while no byte arrives
   a_r1_type_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> $stable(msg_type));

   // R6: a length error never passes
   a_r6_err_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (done && len_err) |-> !pass);

   // R6: length errors come only from the parameter walk
   a_r6_err_multi_only: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> msg_multi);

   // R7: on a complete message the overflow flag matches the length
   a_r7_ovf_matches_len: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !len_err) |-> (buf_ovf == (int'(msg_len) > BUF_DEPTH)));

   // R11: flags hold while no byte arrives
   a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> ($stable(pass) && $stable(len_err) && $stable(buf_ovf)));
endmodule

bind cid_frame_parser cid_frame_parser_chk #(
   .BYTE_W(BYTE_W), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .byte_valid(byte_valid),
   .done(done), .pass(pass), .len_err(len_err), .buf_ovf(buf_ovf),
   .msg_type(msg_type), .msg_len(msg_len), .msg_multi(msg_multi)
);

// File: tb/tb_cid_frame_parser.sv
module tb_cid_frame_parser;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 64;

   typedef logic [7:0] bq_t[$];

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       carrier_ok = 1'b0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       done, pass, len_err, buf_ovf, msg_multi;
   logic [7:0] msg_type, msg_len;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;
   int ndone = 0;

   cid_frame_parser dut (
      .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .byte_valid(byte_valid),
      .byte_data(byte_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .done(done), .pass(pass), .len_err(len_err), .buf_ovf(buf_ovf),
      .msg_type(msg_type), .msg_len(msg_len), .msg_multi(msg_multi)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- reference model ----------------
   logic [7:0] q[$];
   logic [7:0] exp_buf [DEPTH];
   int  m_len = 0, m_next_pt = 0, m_stored = 0;
   logic [7:0] m_type = '0;
   bit  m_multi = 0, m_pass = 0, m_lerr = 0, m_ovf = 0, exp_done = 0;

   task automatic model_byte(input logic [7:0] b);
      int p;
      int s;
      q.push_back(b);
      if (q.size() == 1) begin
         m_type = b; m_multi = b[7];
         m_pass = 0; m_lerr = 0; m_ovf = 0; m_next_pt = 0; m_stored = 0;
      end else if (q.size() == 2) begin
         m_len = int'(b);
      end else begin
         p = q.size() - 3;
         if (p < m_len) begin
            if (p < DEPTH) begin exp_buf[p] = b; m_stored = p + 1; end
            else m_ovf = 1;
            if (m_multi) begin
               if (p == m_next_pt) begin
                  if (p == m_len - 1) begin
                     exp_done = 1; m_lerr = 1; m_pass = 0; q.delete();
                  end
               end else if (p == m_next_pt + 1) begin
                  if (int'(b) > m_len - 1 - p) begin
                     exp_done = 1; m_lerr = 1; m_pass = 0; q.delete();
                  end else begin
                     m_next_pt = p + 1 + int'(b);
                  end
               end
            end
         end else begin
            s = 0;
            foreach (q[i]) s += int'(q[i]);
            exp_done = 1;
            m_pass = ((s % 256) == 0);
            q.delete();
         end
      end
   endtask

   always @(posedge clk) begin
      exp_done = 0;
      if (!rst_n) begin
         q.delete();
         m_type = '0; m_len = 0; m_multi = 0; m_pass = 0; m_lerr = 0; m_ovf = 0;
      end else if (!carrier_ok) begin
         q.delete();
      end else if (byte_valid) begin
         model_byte(byte_data);
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (done) ndone++;
      if (cmp_en) begin
         chk("R4", "done", int'(done), int'(exp_done));
         chk("R4", "pass", int'(pass), int'(m_pass));
         chk("R6", "len_err", int'(len_err), int'(m_lerr));
         chk("R7", "buf_ovf", int'(buf_ovf), int'(m_ovf));
         chk("R1", "msg_type", int'(msg_type), int'(m_type));
         chk("R1", "msg_multi", int'(msg_multi), int'(m_multi));
         chk("R2", "msg_len", int'(msg_len), int'(m_len[7:0]));
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic bq_t add_cs(input bq_t m, input bit bad);
      int s = 0;
      bq_t r = m;
      foreach (m[i]) s += int'(m[i]);
      r.push_back(8'((256 - (s % 256)) % 256) ^ {7'd0, bad});
      return r;
   endfunction

   task automatic send(input bq_t m, input int gap);
      foreach (m[i]) begin
         @(negedge clk);
         byte_valid <= 1'b1;
         byte_data  <= m[i];
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            byte_valid <= 1'b0;
         end
      end
      @(negedge clk);
      byte_valid <= 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic check_buf(input string tag);
      for (int a = 0; a < m_stored; a++) begin
         @(negedge clk);
         rd_addr = 6'(a);
         #1;
         chk(tag, "buffer byte", int'(rd_data), int'(exp_buf[a]));
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      bq_t m;
      int d0;
      repeat (3) @(negedge clk);
      // R9: reset values
      chk("R9", "done", int'(done), 0);
      chk("R9", "pass", int'(pass), 0);
      chk("R9", "len_err", int'(len_err), 0);
      chk("R9", "buf_ovf", int'(buf_ovf), 0);
      chk("R9", "msg_type", int'(msg_type), 0);
      chk("R9", "msg_len", int'(msg_len), 0);
      chk("R9", "msg_multi", int'(msg_multi), 0);
      rst_n = 1'b1;
      carrier_ok = 1'b1;
      cmp_en = 1'b1;
      @(negedge clk);

      // R3 / R4: plain layout, good checksum
      m = add_cs('{8'h04, 8'h08, 8'h30, 8'h34, 8'h31, 8'h35, 8'h31, 8'h36, 8'h32, 8'h31}, 0);
      send(m, 0);
      chk("R4", "pass after good plain message", int'(pass), 1);
      check_buf("R3");

      // R4: bad checksum, R10: idle gaps between bytes
      m = add_cs('{8'h04, 8'h03, 8'h11, 8'h22, 8'h33}, 1);
      send(m, 2);
      chk("R4", "pass after bad checksum", int'(pass), 0);
      chk("R10", "len after gapped message", int'(msg_len), 3);

      // R5: parameter layout with two parameters
      m = add_cs('{8'h80, 8'h09, 8'h01, 8'h02, 8'hA1, 8'hA2, 8'h02, 8'h03, 8'hB1, 8'hB2, 8'hB3}, 0);
      send(m, 1);
      chk("R5", "pass after parameter message", int'(pass), 1);
      check_buf("R5");

      // R5: zero-count parameter then one more
      m = add_cs('{8'h80, 8'h05, 8'h07, 8'h00, 8'h08, 8'h01, 8'hC5}, 0);
      send(m, 0);
      chk("R5", "pass with zero-count parameter", int'(pass), 1);

      // R6: count overruns remaining length
      send('{8'h80, 8'h05, 8'h01, 8'h06}, 0);
      chk("R6", "len_err on count overrun", int'(len_err), 1);
      chk("R6", "pass on count overrun", int'(pass), 0);

      // R6: tag as last payload byte; then a good message follows at once
      send('{8'h82, 8'h04, 8'h01, 8'h01, 8'h55, 8'h02}, 0);
      chk("R6", "len_err on trailing tag", int'(len_err), 1);
      m = add_cs('{8'h04, 8'h01, 8'h99}, 0);
      send(m, 0);
      chk("R11", "len_err cleared by new message", int'(len_err), 0);

      // R2: zero-length message
      m = add_cs('{8'h04, 8'h00}, 0);
      send(m, 0);
      chk("R2", "pass on zero-length message", int'(pass), 1);

      // R7: payload longer than the buffer
      m = '{8'h04, 8'd70};
      for (int i = 0; i < 70; i++) m.push_back(8'(i * 3 + 1));
      m = add_cs(m, 0);
      send(m, 0);
      chk("R7", "buf_ovf on long message", int'(buf_ovf), 1);
      chk("R7", "pass on long message", int'(pass), 1);
      check_buf("R7");

      // R8: carrier drop mid-message
      d0 = ndone;
      send('{8'h04, 8'h05, 8'h10, 8'h20}, 0);
      @(negedge clk);
      carrier_ok <= 1'b0;
      send('{8'h30, 8'h40, 8'h50, 8'h60}, 0);
      carrier_ok <= 1'b1;
      @(negedge clk);
      chk("R8", "no done during abort", ndone, d0);
      m = add_cs('{8'h80, 8'h03, 8'h02, 8'h01, 8'h7E}, 0);
      send(m, 0);
      chk("R8", "message after abort parsed", int'(pass), 1);
      chk("R8", "done count after abort", ndone, d0 + 1);
      check_buf("R8");

      repeat (3) @(negedge clk);
      cmp_en = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule